// File: doc/BRIEF.md
# Platform System Control Register File

This block is a byte-wide register file that sits on a 16-bit I/O port bus of a small workstation board. A port address comes with a write strobe or a read strobe. Writes change a few live control bits: a soft-reset request line, a byte-order mode flag, a disk-activity lamp, a 4-bit system configuration field and an I/O address map selector. Reads return those bits, fixed identification and equipment bytes for the board, or 0xFF for any port the block does not own.

Two password ports do not hold any state. A write to either one sends a single-clock lock-toggle pulse to an external non-volatile memory, one output line for each bank. A separate pair of adjacent ports works as a two-byte read/write scratch store. The memory, the CPU reset sequencer and the cache logic are outside the block. The block only drives their control lines.

Top module: `plat_sysctl`

## Requirements
- R1: While rst_n is low, every stored bit is 0. This covers reset_req, le_mode, disk_led, sys_cfg, map_sparse, both lock pulses, both scratch bytes and rdata.
- R2: A write to port 0x0092 loads reset_req from data bit 0 and le_mode from data bit 1. A read of 0x0092 returns 0x00.
- R3: Reads of ports 0x0800, 0x0802 and 0x0803 return 0xEF, 0xAD and 0xE0. Writes to these ports change no output and no readable value.
- R4: Reads of ports 0x080C, 0x0810, 0x0818 and 0x0823 return 0x3C, 0x39, 0x00 and 0x03.
- R5: A write to port 0x0808 loads disk_led from data bit 0. A read of 0x0808 returns 0xFF.
- R6: A write to port 0x0810 raises lock_pulse_a, and a write to port 0x0812 raises lock_pulse_b. The pulse is high for exactly the one cycle that follows the write strobe, and no other write raises it.
- R7: A write to port 0x081C stores data bits 3:0 in sys_cfg. A read of 0x081C returns {4'b0, sys_cfg}.
- R8: A write to port 0x0850 loads map_sparse from data bit 0. A read of 0x0850 returns {7'b0, map_sparse}.
- R9: A read of any port not named in R2 to R10, including 0x0814, returns 0xFF. Writes to such ports, including 0x0814, have no effect.
- R10: Ports 0x0398 and 0x0399 are two independent 8-bit read/write scratch bytes, selected by the address offset from 0x0398.
- R11: rdata is updated at the clock edge that samples rd_en, and shows the value of the port before any write in that same cycle. rdata holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 16 | I/O port address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| reset_req | output | 1 | Soft reset request to CPU reset logic |
| le_mode | output | 1 | Little-endian byte order mode |
| disk_led | output | 1 | Disk activity lamp |
| sys_cfg | output | 4 | System configuration field |
| map_sparse | output | 1 | I/O map mode: 0 contiguous, 1 sparse |
| lock_pulse_a | output | 1 | Lock-toggle pulse, memory bank 1 |
| lock_pulse_b | output | 1 | Lock-toggle pulse, memory bank 2 |

## Verification
The hardest case to reach is a write that must have no effect. Most of the 4096 ports in the low window read back as 0xFF and store nothing. A stray decode of one of them would only show up as a corrupted control bit or scratch byte.

The stimulus therefore walks every port from 0x0000 to 0x0FFF, plus a set of high addresses that alias the owned ports. Each port gets a write with address-dependent data, then a read. After every write the bench compares all live outputs and both lock pulses against its own model. The bench also checks that a lock pulse drops in the following cycle and that rdata holds while no read strobe is present.

// File: rtl/plat_sysctl_pkg.sv
package plat_sysctl_pkg;

  localparam logic [15:0] PORT_RST  = 16'h0092;
  localparam logic [15:0] PORT_ID0  = 16'h0800;
  localparam logic [15:0] PORT_ID1  = 16'h0802;
  localparam logic [15:0] PORT_ID2  = 16'h0803;
  localparam logic [15:0] PORT_LED  = 16'h0808;
  localparam logic [15:0] PORT_EQP  = 16'h080C;
  localparam logic [15:0] PORT_LKA  = 16'h0810;
  localparam logic [15:0] PORT_LKB  = 16'h0812;
  localparam logic [15:0] PORT_KEY  = 16'h0818;
  localparam logic [15:0] PORT_CFG  = 16'h081C;
  localparam logic [15:0] PORT_CCH  = 16'h0823;
  localparam logic [15:0] PORT_MAP  = 16'h0850;
  localparam logic [15:0] PORT_SCR  = 16'h0398;

  localparam logic [7:0] VAL_ID0  = 8'hEF;
  localparam logic [7:0] VAL_ID1  = 8'hAD;
  localparam logic [7:0] VAL_ID2  = 8'hE0;
  localparam logic [7:0] VAL_EQP  = 8'h3C;
  localparam logic [7:0] VAL_EXT  = 8'h39;
  localparam logic [7:0] VAL_KEY  = 8'h00;
  localparam logic [7:0] VAL_CCH  = 8'h03;
  localparam logic [7:0] VAL_NONE = 8'hFF;

  typedef struct packed {
    logic rst;
    logic id0;
    logic id1;
    logic id2;
    logic led;
    logic eqp;
    logic lka;
    logic lkb;
    logic key;
    logic cfg;
    logic cch;
    logic map;
    logic scr;
  } port_sel_t;

endpackage

// File: rtl/plat_sysctl_dec.sv
module plat_sysctl_dec
  import plat_sysctl_pkg::*;
#(
  parameter int AW    = 16,
  parameter int SCR_N = 2,
  parameter int SCR_IW = 1
) (
  input  logic [AW-1:0]     addr,
  output port_sel_t         sel,
  output logic [SCR_IW-1:0] scr_idx
);

  localparam logic [AW-1:0] SCR_LO = AW'(PORT_SCR);
  localparam logic [AW-1:0] SCR_HI = AW'(PORT_SCR) + AW'(SCR_N);

  logic [AW-1:0] scr_off;

  always_comb begin
    scr_off     = addr - SCR_LO;
    scr_idx     = scr_off[SCR_IW-1:0];
    sel.rst     = (addr == AW'(PORT_RST));
    sel.id0     = (addr == AW'(PORT_ID0));
    sel.id1     = (addr == AW'(PORT_ID1));
    sel.id2     = (addr == AW'(PORT_ID2));
    sel.led     = (addr == AW'(PORT_LED));
    sel.eqp     = (addr == AW'(PORT_EQP));
    sel.lka     = (addr == AW'(PORT_LKA));
    sel.lkb     = (addr == AW'(PORT_LKB));
    sel.key     = (addr == AW'(PORT_KEY));
    sel.cfg     = (addr == AW'(PORT_CFG));
    sel.cch     = (addr == AW'(PORT_CCH));
    sel.map     = (addr == AW'(PORT_MAP));
    sel.scr     = (addr >= SCR_LO) && (addr < SCR_HI);
  end

endmodule

// File: rtl/plat_sysctl_ctl.sv
module plat_sysctl_ctl #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] wd,
  input  logic             we_rst,
  input  logic             we_led,
  input  logic             we_cfg,
  input  logic             we_map,
  input  logic             we_lka,
  input  logic             we_lkb,
  output logic             reset_req,
  output logic             le_mode,
  output logic             disk_led,
  output logic [CFG_W-1:0] sys_cfg,
  output logic             map_sparse,
  output logic             lock_pulse_a,
  output logic             lock_pulse_b
);

  logic             rst_d, le_d, led_d, map_d, lka_d, lkb_d;
  logic [CFG_W-1:0] cfg_d;

  // next state
  always_comb begin
    rst_d = reset_req;
    le_d  = le_mode;
    led_d = disk_led;
    cfg_d = sys_cfg;
    map_d = map_sparse;
    lka_d = we_lka;
    lkb_d = we_lkb;
    if (we_rst) begin
      rst_d = wd[0];
      le_d  = wd[1];
    end
    if (we_led) led_d = wd[0];
    if (we_cfg) cfg_d = wd;
    if (we_map) map_d = wd[0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_req    <= 1'b0;
      le_mode      <= 1'b0;
      disk_led     <= 1'b0;
      sys_cfg      <= '0;
      map_sparse   <= 1'b0;
      lock_pulse_a <= 1'b0;
      lock_pulse_b <= 1'b0;
    end else begin
      reset_req    <= rst_d;
      le_mode      <= le_d;
      disk_led     <= led_d;
      sys_cfg      <= cfg_d;
      map_sparse   <= map_d;
      lock_pulse_a <= lka_d;
      lock_pulse_b <= lkb_d;
    end
  end

  AST_LKA_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse_a |-> $past(we_lka)); // R6
  AST_LKB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse_b |-> $past(we_lkb)); // R6
  AST_LK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_pulse_a && lock_pulse_b)); // R6
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_cfg |=> $stable(sys_cfg)); // R7
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_map |=> $stable(map_sparse)); // R8

endmodule

// File: rtl/plat_sysctl_scr.sv
module plat_sysctl_scr #(
  parameter int DW     = 8,
  parameter int SCR_N  = 2,
  parameter int SCR_IW = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SCR_IW-1:0] idx,
  input  logic [DW-1:0]     wd,
  output logic [DW-1:0]     rd
);

  logic [DW-1:0] mem_q [SCR_N];
  logic [DW-1:0] mem_d [SCR_N];

  for (genvar i = 0; i < SCR_N; i++) begin : g_ent
    logic hit;
    always_comb begin
      hit      = we && (idx == SCR_IW'(i));
      mem_d[i] = hit ? wd : mem_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '0;
      else        mem_q[i] <= mem_d[i];
    end
    AST_SCR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (idx == SCR_IW'(i))) |=> $stable(mem_q[i])); // R10
  end

  always_comb begin
    rd = '0;
    for (int k = 0; k < SCR_N; k++)
      if (idx == SCR_IW'(k)) rd = mem_q[k];
  end

endmodule

// File: rtl/plat_sysctl.sv
module plat_sysctl
  import plat_sysctl_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CFG_W = 4,
  parameter int SCR_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             reset_req,
  output logic             le_mode,
  output logic             disk_led,
  output logic [CFG_W-1:0] sys_cfg,
  output logic             map_sparse,
  output logic             lock_pulse_a,
  output logic             lock_pulse_b
);

  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1;

  port_sel_t         sel;
  logic [SCR_IW-1:0] scr_idx;
  logic [DW-1:0]     scr_rd;
  logic [DW-1:0]     rd_next;

  plat_sysctl_dec #(.AW(AW), .SCR_N(SCR_N), .SCR_IW(SCR_IW)) u_dec (
    .addr    (addr),
    .sel     (sel),
    .scr_idx (scr_idx)
  );

  plat_sysctl_ctl #(.CFG_W(CFG_W)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wd           (wdata[CFG_W-1:0]),
    .we_rst       (wr_en && sel.rst),
    .we_led       (wr_en && sel.led),
    .we_cfg       (wr_en && sel.cfg),
    .we_map       (wr_en && sel.map),
    .we_lka       (wr_en && sel.lka),
    .we_lkb       (wr_en && sel.lkb),
    .reset_req    (reset_req),
    .le_mode      (le_mode),
    .disk_led     (disk_led),
    .sys_cfg      (sys_cfg),
    .map_sparse   (map_sparse),
    .lock_pulse_a (lock_pulse_a),
    .lock_pulse_b (lock_pulse_b)
  );

  plat_sysctl_scr #(.DW(DW), .SCR_N(SCR_N), .SCR_IW(SCR_IW)) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en && sel.scr),
    .idx   (scr_idx),
    .wd    (wdata),
    .rd    (scr_rd)
  );

  // read mux (next state of rdata)
  always_comb begin
    rd_next = DW'(VAL_NONE);
    if      (sel.rst) rd_next = '0;
    else if (sel.id0) rd_next = DW'(VAL_ID0);
    else if (sel.id1) rd_next = DW'(VAL_ID1);
    else if (sel.id2) rd_next = DW'(VAL_ID2);
    else if (sel.eqp) rd_next = DW'(VAL_EQP);
    else if (sel.lka) rd_next = DW'(VAL_EXT);
    else if (sel.key) rd_next = DW'(VAL_KEY);
    else if (sel.cch) rd_next = DW'(VAL_CCH);
    else if (sel.cfg) rd_next = DW'(sys_cfg);
    else if (sel.map) rd_next = DW'(map_sparse);
    else if (sel.scr) rd_next = scr_rd;
    else if (sel.led || sel.lkb) rd_next = DW'(VAL_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R11
  AST_ID0_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(PORT_ID0)) |=> (rdata == DW'(VAL_ID0))); // R3
  AST_RST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(PORT_RST)) |=> (rdata == '0)); // R2

endmodule

// File: tb/sim_plat_sysctl.sv
module sim_plat_sysctl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        wr_en, rd_en;
  logic [7:0]  wdata, rdata;
  logic        reset_req, le_mode, disk_led, map_sparse;
  logic [3:0]  sys_cfg;
  logic        lock_pulse_a, lock_pulse_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic       m_rst, m_le, m_led, m_map;
  logic [3:0] m_cfg;
  logic [7:0] m_scr [2];

  always #2 clk = ~clk;

  plat_sysctl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .reset_req(reset_req), .le_mode(le_mode),
    .disk_led(disk_led), .sys_cfg(sys_cfg), .map_sparse(map_sparse),
    .lock_pulse_a(lock_pulse_a), .lock_pulse_b(lock_pulse_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    case (a)
      16'h0092: return 8'h00;
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h0823: return 8'h03;
      16'h081C: return {4'h0, m_cfg};
      16'h0850: return {7'h0, m_map};
      16'h0398: return m_scr[0];
      16'h0399: return m_scr[1];
      default:  return 8'hFF;
    endcase
  endfunction

  task automatic check_outs(input string req);
    chk(req, reset_req, m_rst);
    chk(req, le_mode, m_le);
    chk(req, disk_led, m_led);
    chk(req, sys_cfg, m_cfg);
    chk(req, map_sparse, m_map);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      16'h0092: begin m_rst = d[0]; m_le = d[1]; end
      16'h0808: m_led = d[0];
      16'h081C: m_cfg = d[3:0];
      16'h0850: m_map = d[0];
      16'h0398: m_scr[0] = d;
      16'h0399: m_scr[1] = d;
      default: ;
    endcase
    check_outs("R9_write_effects");
    chk("R6_pulse_a", lock_pulse_a, a == 16'h0810);
    chk("R6_pulse_b", lock_pulse_b, a == 16'h0812);
    @(negedge clk);
    if (a == 16'h0810 || a == 16'h0812) begin
      chk("R6_pulse_a_drop", lock_pulse_a, 0);
      chk("R6_pulse_b_drop", lock_pulse_b, 0);
    end
  endtask

  task automatic do_read(input logic [15:0] a, input string req);
    logic [7:0] e;
    e = exp_rd(a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rdata, e);
    addr = ~a;
    @(negedge clk);
    chk("R11_hold", rdata, e);
  endtask

  initial begin
    addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0; rst_n = 1'b0;
    m_rst = 0; m_le = 0; m_led = 0; m_map = 0; m_cfg = 0;
    m_scr[0] = 0; m_scr[1] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_outs("R1_reset");
    chk("R1_reset_rdata", rdata, 0);
    chk("R1_reset_lk", {lock_pulse_a, lock_pulse_b}, 0);
    rst_n = 1'b1;
    do_read(16'h0398, "R1_scr0");
    do_read(16'h0399, "R1_scr1");

    // R2 R5 R7 R8 directed bit patterns
    for (int v = 0; v < 4; v++) begin
      do_write(16'h0092, 8'(v));
      do_read(16'h0092, "R2_read_zero");
    end
    do_write(16'h0808, 8'h01);
    do_read(16'h0808, "R5_read_ff");
    do_write(16'h0808, 8'hFE);
    for (int v = 0; v < 256; v += 17) begin
      do_write(16'h081C, 8'(v));
      do_read(16'h081C, "R7_cfg");
    end
    do_write(16'h0850, 8'h03);
    do_read(16'h0850, "R8_map");
    do_write(16'h0850, 8'h02);
    do_read(16'h0850, "R8_map");
    // R6 back-to-back lock writes
    do_write(16'h0810, 8'h00);
    do_write(16'h0812, 8'hFF);
    // R3 writes to identity ports are ignored
    do_write(16'h0800, 8'h00);
    do_read(16'h0800, "R3_id0");
    do_write(16'h0802, 8'h00);
    do_read(16'h0802, "R3_id1");
    do_write(16'h0803, 8'h00);
    do_read(16'h0803, "R3_id2");
    // R4 fixed bytes
    do_read(16'h080C, "R4_eqp");
    do_read(16'h0810, "R4_ext");
    do_read(16'h0818, "R4_key");
    do_read(16'h0823, "R4_cache");
    // R9 port 0x814
    do_write(16'h0814, 8'hFF);
    do_read(16'h0814, "R9_l2inv");
    // R10 scratch independence
    do_write(16'h0398, 8'h5C);
    do_write(16'h0399, 8'hC5);
    do_read(16'h0398, "R10_scr0");
    do_read(16'h0399, "R10_scr1");

    // sweep: every port of the low window, write then read (R9 R10 R3)
    for (int a = 0; a < 4096; a++) begin
      do_write(16'(a), 8'(a) ^ 8'h5A);
      do_read(16'(a), "R9_sweep");
    end
    // aliases of owned ports in the high address space (R9)
    for (int h = 1; h < 16; h++) begin
      do_write({4'(h), 12'h092}, 8'h03);
      do_read({4'(h), 12'h81C}, "R9_alias");
      do_read({4'(h), 12'h398}, "R9_alias");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule